// File: doc/BRIEF.md
# Flash FIFO Level Interrupt Unit

This block sits between a register bus and a flash operation engine and holds two word queues. The program queue carries words from software to the engine. The read queue carries words from the engine back to software. Each queue has 16 entries of 32 bits. Every data path is a valid/ready stream, and a word moves only in a cycle where both valid and ready are high.

The ready and valid signals apply back-pressure. The program queue's input ready is high only when three things hold: a program operation is flagged active, the queue is not full, and the queue clear is not held. The read queue's input ready is high when the queue is not full and the clear is not held. Each output valid is high when its queue holds a word and the clear is not held. Each output data port shows the oldest word.

The block reports full and empty status for both queues. It latches four interrupt causes into sticky state bits, and software clears a bit by writing 1 to it. Two causes follow status edges: the program queue going empty and the read queue going full. The other two follow occupancy crossing a software-set threshold. The program threshold triggers while the queue drains, and the read threshold triggers while the queue fills.

Top module: `flash_fifo_irq`

## Requirements
- R1: Each queue returns its 32-bit words in the order they were accepted and holds up to 16 words. The output data port shows the oldest word whenever the output valid is high.
- R2: A word transfers only when valid and ready are both high. Input ready is low while a queue holds 16 words, and output valid is low while it holds none. An offered word that is not accepted leaves the contents unchanged.
- R3: The program queue's input ready is low whenever `prog_op_active_i` is low. A word offered in that state is not stored.
- R4: After reset, both empty flags are 1, both full flags are 0 and all interrupt state bits are 0. A full flag is 1 exactly when its queue holds 16 words, and an empty flag is 1 exactly when its queue holds none.
- R5: While `fifo_clear_i` is high, both queues become and stay empty. During that time, both input readies and both output valids are low.
- R6: Interrupt state bit 1 sets in the cycle where the program queue occupancy goes from above the program threshold to at or below it.
- R7: Interrupt state bit 3 sets in the cycle where the read queue occupancy goes from below the read threshold to at or above it.
- R8: Both thresholds are 5-bit registers. They reset to 15 and load from `cfg_prog_lvl_i` and `cfg_rd_lvl_i` in a cycle with `cfg_lvl_we_i` high. A new value applies from the following cycle.
- R9: Interrupt state bit 0 sets when the program empty flag rises. Interrupt state bit 2 sets when the read full flag rises.
- R10: An interrupt state bit stays set until software writes 1 to it through `irq_clr_i`. If a new event arrives in the same cycle as the clear, the bit remains set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_op_active_i | input | 1 | A program operation is in progress |
| fifo_clear_i | input | 1 | Holds both queues empty while high |
| cfg_lvl_we_i | input | 1 | Loads both thresholds |
| cfg_prog_lvl_i | input | 5 | New program-queue threshold |
| cfg_rd_lvl_i | input | 5 | New read-queue threshold |
| pf_in_valid_i | input | 1 | Software offers a program word |
| pf_in_ready_o | output | 1 | Program queue accepts a word |
| pf_in_data_i | input | 32 | Program word from software |
| pf_out_valid_o | output | 1 | Program word available to the engine |
| pf_out_ready_i | input | 1 | Engine takes a program word |
| pf_out_data_o | output | 32 | Oldest program word |
| rf_in_valid_i | input | 1 | Engine offers a read word |
| rf_in_ready_o | output | 1 | Read queue accepts a word |
| rf_in_data_i | input | 32 | Read word from the engine |
| rf_out_valid_o | output | 1 | Read word available to software |
| rf_out_ready_i | input | 1 | Software takes a read word |
| rf_out_data_o | output | 32 | Oldest read word |
| pf_full_o | output | 1 | Program queue holds 16 words |
| pf_empty_o | output | 1 | Program queue holds no word |
| rf_full_o | output | 1 | Read queue holds 16 words |
| rf_empty_o | output | 1 | Read queue holds no word |
| irq_clr_i | input | 4 | Write-1-to-clear for the interrupt state |
| irq_state_o | output | 4 | Sticky causes: 0 program empty, 1 program level, 2 read full, 3 read level |

## Verification
The hardest case to reach is a threshold crossing that happens at a queue boundary. One example is the program queue draining from 16 to 15 under the reset threshold. Another is the read queue reaching full in the same cycle it reaches its threshold. Both need a queue pushed all the way to capacity while its consumer is held off. The program side can only be filled while an operation is flagged active.

The stimulus runs in phases. Early phases are biased to fill one queue and then drain it, before any threshold is written, so the reset thresholds are exercised. Later phases write random thresholds, toggle the operation flag, hold the clear for runs of cycles and clear interrupt bits at random. A behavioural model with queues predicts every port on every cycle.

// File: rtl/flash_fifo_pkg.sv
package flash_fifo_pkg;
  localparam int IRQ_N = 4;
  typedef enum int {
    IRQ_PG_EMPTY = 0,
    IRQ_PG_LVL   = 1,
    IRQ_RD_FULL  = 2,
    IRQ_RD_LVL   = 3
  } irq_idx_e;
endpackage

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [W-1:0]  push_data_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] cnt_q_o,
  output logic [CW-1:0] cnt_d_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign cnt_d_o = clr_i ? '0 :
                   cnt_q + {{(CW-1){1'b0}}, push_i} - {{(CW-1){1'b0}}, pop_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= adv(wptr_q);
      if (pop_i)  rptr_q <= adv(rptr_q);
      cnt_q <= cnt_d_o;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !clr_i) mem[wptr_q] <= push_data_i;
  end

  assign head_o  = mem[rptr_q];
  assign cnt_q_o = cnt_q;
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/lvl_watch.sv
module lvl_watch #(
  parameter int CW   = 5,
  parameter int LW   = 5,
  parameter bit FILL = 1'b0
) (
  input  logic [CW-1:0] cnt_old_i,
  input  logic [CW-1:0] cnt_new_i,
  input  logic [LW-1:0] level_i,
  output logic          evt_o
);
  generate
    if (FILL) begin : g_fill
      assign evt_o = (int'(cnt_old_i) < int'(level_i)) &&
                     (int'(cnt_new_i) >= int'(level_i));
    end else begin : g_drain
      assign evt_o = (int'(cnt_old_i) > int'(level_i)) &&
                     (int'(cnt_new_i) <= int'(level_i));
    end
  endgenerate
endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] state_o
);
  logic [N-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= '0;
    else         state_q <= (state_q & ~clr_i) | evt_i;
  end

  assign state_o = state_q;
endmodule

// File: rtl/flash_fifo_irq.sv
module flash_fifo_irq #(
  parameter int W       = 32,
  parameter int DEPTH   = 16,
  parameter int LVLW    = 5,
  parameter int LVL_RST = 15
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          prog_op_active_i,
  input  logic                          fifo_clear_i,
  input  logic                          cfg_lvl_we_i,
  input  logic [LVLW-1:0]               cfg_prog_lvl_i,
  input  logic [LVLW-1:0]               cfg_rd_lvl_i,
  input  logic                          pf_in_valid_i,
  output logic                          pf_in_ready_o,
  input  logic [W-1:0]                  pf_in_data_i,
  output logic                          pf_out_valid_o,
  input  logic                          pf_out_ready_i,
  output logic [W-1:0]                  pf_out_data_o,
  input  logic                          rf_in_valid_i,
  output logic                          rf_in_ready_o,
  input  logic [W-1:0]                  rf_in_data_i,
  output logic                          rf_out_valid_o,
  input  logic                          rf_out_ready_i,
  output logic [W-1:0]                  rf_out_data_o,
  output logic                          pf_full_o,
  output logic                          pf_empty_o,
  output logic                          rf_full_o,
  output logic                          rf_empty_o,
  input  logic [flash_fifo_pkg::IRQ_N-1:0] irq_clr_i,
  output logic [flash_fifo_pkg::IRQ_N-1:0] irq_state_o
);
  import flash_fifo_pkg::*;

  localparam int CW = $clog2(DEPTH + 1);

  logic [LVLW-1:0] prog_lvl_q, rd_lvl_q;
  logic [CW-1:0]   pf_cnt_q, pf_cnt_d, rf_cnt_q, rf_cnt_d;
  logic            pf_push, pf_pop, rf_push, rf_pop;
  logic [IRQ_N-1:0] evt;

  // threshold registers (R8)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_lvl_q <= LVLW'(LVL_RST);
      rd_lvl_q   <= LVLW'(LVL_RST);
    end else if (cfg_lvl_we_i) begin
      prog_lvl_q <= cfg_prog_lvl_i;
      rd_lvl_q   <= cfg_rd_lvl_i;
    end
  end

  // stream handshakes
  assign pf_in_ready_o  = prog_op_active_i && !fifo_clear_i && !pf_full_o;
  assign pf_out_valid_o = !fifo_clear_i && !pf_empty_o;
  assign rf_in_ready_o  = !fifo_clear_i && !rf_full_o;
  assign rf_out_valid_o = !fifo_clear_i && !rf_empty_o;

  assign pf_push = pf_in_valid_i  && pf_in_ready_o;
  assign pf_pop  = pf_out_valid_o && pf_out_ready_i;
  assign rf_push = rf_in_valid_i  && rf_in_ready_o;
  assign rf_pop  = rf_out_valid_o && rf_out_ready_i;

  fifo_store #(.W(W), .DEPTH(DEPTH), .CW(CW)) i_pf (
    .clk_i, .rst_ni, .clr_i(fifo_clear_i),
    .push_i(pf_push), .push_data_i(pf_in_data_i), .pop_i(pf_pop),
    .head_o(pf_out_data_o), .cnt_q_o(pf_cnt_q), .cnt_d_o(pf_cnt_d),
    .full_o(pf_full_o), .empty_o(pf_empty_o)
  );

  fifo_store #(.W(W), .DEPTH(DEPTH), .CW(CW)) i_rf (
    .clk_i, .rst_ni, .clr_i(fifo_clear_i),
    .push_i(rf_push), .push_data_i(rf_in_data_i), .pop_i(rf_pop),
    .head_o(rf_out_data_o), .cnt_q_o(rf_cnt_q), .cnt_d_o(rf_cnt_d),
    .full_o(rf_full_o), .empty_o(rf_empty_o)
  );

  // status-edge causes
  assign evt[IRQ_PG_EMPTY] = (pf_cnt_q != '0) && (pf_cnt_d == '0);
  assign evt[IRQ_RD_FULL]  = (rf_cnt_q != CW'(DEPTH)) && (rf_cnt_d == CW'(DEPTH));

  // threshold causes: program drains, read fills
  lvl_watch #(.CW(CW), .LW(LVLW), .FILL(1'b0)) i_pf_lvl (
    .cnt_old_i(pf_cnt_q), .cnt_new_i(pf_cnt_d), .level_i(prog_lvl_q),
    .evt_o(evt[IRQ_PG_LVL])
  );
  lvl_watch #(.CW(CW), .LW(LVLW), .FILL(1'b1)) i_rf_lvl (
    .cnt_old_i(rf_cnt_q), .cnt_new_i(rf_cnt_d), .level_i(rd_lvl_q),
    .evt_o(evt[IRQ_RD_LVL])
  );

  irq_bank #(.N(IRQ_N)) i_irq (
    .clk_i, .rst_ni, .evt_i(evt), .clr_i(irq_clr_i), .state_o(irq_state_o)
  );
endmodule

// File: rtl/flash_fifo_irq_chk.sv
module flash_fifo_irq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       prog_op_active_i,
  input logic       fifo_clear_i,
  input logic       pf_in_ready_o,
  input logic       rf_out_valid_o,
  input logic       pf_out_valid_o,
  input logic       rf_in_ready_o,
  input logic       pf_full_o,
  input logic       pf_empty_o,
  input logic       rf_full_o,
  input logic       rf_empty_o,
  input logic [3:0] irq_clr_i,
  input logic [3:0] irq_state_o
);
  assert_no_push_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_full_o |-> !pf_in_ready_o) and (rf_full_o |-> !rf_in_ready_o));

  assert_no_pop_empty_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_empty_o |-> !pf_out_valid_o) and (rf_empty_o |-> !rf_out_valid_o));

  assert_prog_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_op_active_i |-> !pf_in_ready_o);

  assert_clear_empties_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_clear_i |=> (pf_empty_o && rf_empty_o));

  assert_empty_irq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pf_empty_o) |-> irq_state_o[0]);

  assert_full_irq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rf_full_o) |-> irq_state_o[2]);

  assert_irq_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((irq_state_o & $past(irq_state_o & ~irq_clr_i)) ==
              $past(irq_state_o & ~irq_clr_i)));
endmodule

bind flash_fifo_irq flash_fifo_irq_chk i_chk (.*);

// File: tb/test_flash_fifo_irq.sv
module test_flash_fifo_irq;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        op = 1'b0, clr = 1'b0, lvl_we = 1'b0;
  logic [4:0]  cfg_p = 5'd0, cfg_r = 5'd0;
  logic        pin_v = 1'b0, pout_r = 1'b0, rin_v = 1'b0, rout_r = 1'b0;
  logic [31:0] pin_d = '0, rin_d = '0;
  logic [3:0]  iclr = '0;
  logic        pin_rdy, pout_v, rin_rdy, rout_v;
  logic [31:0] pout_d, rout_d;
  logic        pf_full, pf_empty, rf_full, rf_empty;
  logic [3:0]  irq;

  always #4 clk = ~clk;

  flash_fifo_irq i_flash_fifo_irq (
    .clk_i(clk), .rst_ni(rst_n), .prog_op_active_i(op), .fifo_clear_i(clr),
    .cfg_lvl_we_i(lvl_we), .cfg_prog_lvl_i(cfg_p), .cfg_rd_lvl_i(cfg_r),
    .pf_in_valid_i(pin_v), .pf_in_ready_o(pin_rdy), .pf_in_data_i(pin_d),
    .pf_out_valid_o(pout_v), .pf_out_ready_i(pout_r), .pf_out_data_o(pout_d),
    .rf_in_valid_i(rin_v), .rf_in_ready_o(rin_rdy), .rf_in_data_i(rin_d),
    .rf_out_valid_o(rout_v), .rf_out_ready_i(rout_r), .rf_out_data_o(rout_d),
    .pf_full_o(pf_full), .pf_empty_o(pf_empty), .rf_full_o(rf_full), .rf_empty_o(rf_empty),
    .irq_clr_i(iclr), .irq_state_o(irq)
  );

  // behavioural reference
  logic [31:0] mpq[$], mrq[$];
  int  mplvl = 15, mrlvl = 15, po, pn, ro, rn;
  bit  lvl_written = 0;
  bit  [3:0] mirq = '0, ev;
  bit  pw, pr, rw, rr;
  int  checks = 0, fails = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mpq.delete(); mrq.delete(); mirq = '0; mplvl = 15; mrlvl = 15;
    end else begin
      po = mpq.size(); ro = mrq.size();
      pw = pin_v && op && !clr && po < 16;
      pr = pout_r && !clr && po > 0;
      rw = rin_v && !clr && ro < 16;
      rr = rout_r && !clr && ro > 0;
      if (clr) begin
        mpq.delete(); mrq.delete();
      end else begin
        if (pr) void'(mpq.pop_front());
        if (pw) mpq.push_back(pin_d);
        if (rr) void'(mrq.pop_front());
        if (rw) mrq.push_back(rin_d);
      end
      pn = mpq.size(); rn = mrq.size();
      ev[0] = (po != 0) && (pn == 0);
      ev[1] = (po > mplvl) && (pn <= mplvl);
      ev[2] = (ro != 16) && (rn == 16);
      ev[3] = (ro < mrlvl) && (rn >= mrlvl);
      mirq = (mirq & ~iclr) | ev;
      if (lvl_we) begin mplvl = cfg_p; mrlvl = cfg_r; lvl_written = 1; end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    bit epin = op && !clr && mpq.size() < 16;
    bit epo  = !clr && mpq.size() > 0;
    bit erin = !clr && mrq.size() < 16;
    bit ero  = !clr && mrq.size() > 0;
    chk(pin_rdy == epin, op ? "R2" : "R3", "pf_in_ready", pin_rdy, epin);
    chk(pout_v == epo, "R2", "pf_out_valid", pout_v, epo);
    chk(rin_rdy == erin, "R2", "rf_in_ready", rin_rdy, erin);
    chk(rout_v == ero, "R2", "rf_out_valid", rout_v, ero);
    if (epo) chk(pout_d == mpq[0], "R1", "pf_out_data", pout_d, mpq[0]);
    if (ero) chk(rout_d == mrq[0], "R1", "rf_out_data", rout_d, mrq[0]);
    chk(pf_full == (mpq.size() == 16), "R4", "pf_full", pf_full, mpq.size() == 16);
    chk(pf_empty == (mpq.size() == 0), "R4", "pf_empty", pf_empty, mpq.size() == 0);
    chk(rf_full == (mrq.size() == 16), "R4", "rf_full", rf_full, mrq.size() == 16);
    chk(rf_empty == (mrq.size() == 0), "R4", "rf_empty", rf_empty, mrq.size() == 0);
    if (clr) chk(!pin_rdy && !pout_v && !rin_rdy && !rout_v, "R5", "handshakes in clear",
                 {pin_rdy, pout_v, rin_rdy, rout_v}, 0);
    chk(irq[0] == mirq[0], "R9", "irq prog empty", irq[0], mirq[0]);
    chk(irq[2] == mirq[2], "R9", "irq read full", irq[2], mirq[2]);
    chk(irq[1] == mirq[1], lvl_written ? "R6" : "R8", "irq prog level", irq[1], mirq[1]);
    chk(irq[3] == mirq[3], lvl_written ? "R7" : "R8", "irq read level", irq[3], mirq[3]);
    chk(irq == mirq, "R10", "irq state", irq, mirq);
  endtask

  function automatic bit hit(input int pct);
    return ($urandom_range(99, 0) < pct);
  endfunction

  bit done = 0;

  initial begin
    int ppin, ppout, prin, prout, pclr, pwe, pic;
    repeat (3) @(negedge clk);
    // reset state, R4
    chk(pf_empty && rf_empty && !pf_full && !rf_full, "R4", "reset flags",
        {pf_full, pf_empty, rf_full, rf_empty}, 4'b0101);
    chk(irq == 4'b0, "R4", "reset irq", irq, 0);
    rst_n = 1'b1;
    for (int ph = 0; ph < 10; ph++) begin
      case (ph)
        0: begin ppin = 0;  ppout = 0;  prin = 90; prout = 3;  pclr = 0; pwe = 0;  pic = 0; end
        1: begin ppin = 0;  ppout = 0;  prin = 5;  prout = 80; pclr = 0; pwe = 0;  pic = 5; end
        2: begin ppin = 90; ppout = 3;  prin = 0;  prout = 0;  pclr = 0; pwe = 0;  pic = 0; end
        3: begin ppin = 5;  ppout = 80; prin = 0;  prout = 0;  pclr = 0; pwe = 0;  pic = 5; end
        default: begin
          ppin = $urandom_range(90, 10); ppout = $urandom_range(90, 10);
          prin = $urandom_range(90, 10); prout = $urandom_range(90, 10);
          pclr = 2; pwe = 3; pic = 8;
        end
      endcase
      for (int c = 0; c < 500; c++) begin
        @(negedge clk);
        compare_all();
        pin_v  = hit(ppin);  pout_r = hit(ppout);
        rin_v  = hit(prin);  rout_r = hit(prout);
        pin_d  = $urandom;   rin_d  = $urandom;
        if (ph < 4) op = (ph == 2 || ph == 3);
        else if (hit(3)) op = ~op;
        if (clr) clr = !hit(30);
        else     clr = hit(pclr);
        lvl_we = hit(pwe);
        cfg_p  = 5'($urandom_range(17, 0));
        cfg_r  = 5'($urandom_range(17, 0));
        iclr   = hit(pic) ? 4'($urandom) : 4'b0;
      end
    end
    @(negedge clk);
    compare_all();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule